// File: doc/BRIEF.md
# System Exception Control Register File

This block is the software-facing register file for the core system exceptions of a small processor: the non-maskable interrupt, the pendable service call, the periodic tick, the three configurable faults (memory management, bus, usage), the supervisor call and the debug monitor. It does not arbitrate priorities and does not hold the pending or active state itself. The exception logic reports that state on status inputs, and this block packs it into fixed bit positions for reads. Register writes come back out as one-cycle set-pending and clear-pending strobes indexed by exception number.

The block also stores the vector-table base address and the three fault enable bits. It turns a key-protected write into a one-cycle system reset request. It forwards a software trigger for external interrupts as a valid strobe with a 9-bit interrupt number. The fault status words are decoded and read as zero. Any other offset reads as zero and raises an error flag.

Every result is registered. Read data, the error flag, the strobes, the reset request and the trigger are all valid in the cycle after the access is sampled.

Top module: `sysexc_regfile`

## Requirements
- R1: After reset, every output is zero: read data, error flag, strobes, reset request, trigger valid and number, vector base and fault enables.
- R2: A read of byte offset 0x004 returns NUM_IRQ/32 − 1, which is 1 for the default of 64 interrupts.
- R3: A write to offset 0xD04 with bit 31 set gives a one-cycle set strobe on exception 2 (set_pend = 0x0004).
- R4: In a write to 0xD04, bit 28 gives a set strobe and bit 27 a clear strobe on exception 14 (bit 14 of set_pend or clr_pend). When both bits are 1, only the set strobe appears.
- R5: In a write to 0xD04, bit 26 gives a set strobe and bit 25 a clear strobe on exception 15 (bit 15), with the same set-over-clear rule.
- R6: A read of 0xD04 returns the active exception number in bits 8:0 and the highest pending vector in bits 20:12. Bit 26 shows the pending state of exception 15, bit 28 that of exception 14, and bit 31 that of exception 2. All other bits are zero.
- R7: A write to 0xD08 stores the data with bits 6:0 forced to zero. The stored value is driven on vbase and read back at 0xD08.
- R8: A write to 0xD0C whose bits 31:16 equal 0x05FA and whose bit 2 is set gives rst_req high for exactly one cycle. A write with any other key has no effect.
- R9: A read of 0xD24 packs the status inputs as follows. Active bits: exception 4→bit 0, 5→1, 6→3, 11→7, 12→8, 14→10, 15→11. Pending bits: exception 6→12, 4→13, 5→14, 11→15. Enable bits: memory fault 16, bus fault 17, usage fault 18. All other bits are zero.
- R10: A write to 0xD24 changes only the fault enables: data bit 16 goes to fault_en[0], bit 17 to fault_en[1] and bit 18 to fault_en[2].
- R11: A write to 0xF00 gives a one-cycle trig_valid with trig_num = data bits 8:0, but only when that number is below NUM_IRQ.
- R12: Reads of the fault status offsets 0xD28 to 0xD3C return zero without the error flag.
- R13: A read of an unmapped offset returns zero with reg_err high for one cycle. A write to an unmapped offset changes no output or stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read, zero otherwise |
| reg_err | output | 1 | One-cycle flag for a read of an unmapped offset |
| exc_active | input | 16 | Active state per exception number |
| exc_pending | input | 16 | Pending state per exception number |
| act_num | input | 9 | Number of the exception now active |
| top_pend | input | 9 | Highest pending vector number |
| set_pend | output | 16 | One-cycle set-pending strobes per exception number |
| clr_pend | output | 16 | One-cycle clear-pending strobes per exception number |
| rst_req | output | 1 | One-cycle system reset request |
| trig_valid | output | 1 | One-cycle software trigger strobe |
| trig_num | output | 9 | External interrupt number of the trigger |
| vbase | output | 32 | Stored vector-table base |
| fault_en | output | 3 | Enables for usage, bus and memory faults (bits 2:0) |

## Verification
Every result of an access sampled at clock edge k is due just after edge k. This covers read data, the error flag, the strobes, the reset request and the trigger. Strobes and the error flag must be low again after edge k+1. The bench drives each access on a falling edge and removes it on the next falling edge. It checks the outputs at that second falling edge, and checks again one falling edge later that the pulses have dropped. Stored state (vbase, fault_en) is checked both on its port and by reading it back through the register interface.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;

  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int EXC_W   = 16;
  localparam int VEC_W   = 9;
  localparam int WOFS_W  = ADDR_W - 2;
  localparam int N_PAIR  = 2;

  // exception numbers
  localparam int EXC_NMI     = 2;
  localparam int EXC_MEM     = 4;
  localparam int EXC_BUS     = 5;
  localparam int EXC_USAGE   = 6;
  localparam int EXC_SVC     = 11;
  localparam int EXC_DEBUG   = 12;
  localparam int EXC_PENDSV  = 14;
  localparam int EXC_SYSTICK = 15;

  // word offsets (byte offset >> 2)
  localparam logic [WOFS_W-1:0] W_CTYPE  = 10'h001;
  localparam logic [WOFS_W-1:0] W_CTRL   = 10'h341;
  localparam logic [WOFS_W-1:0] W_VBASE  = 10'h342;
  localparam logic [WOFS_W-1:0] W_RSTCTL = 10'h343;
  localparam logic [WOFS_W-1:0] W_HSTAT  = 10'h349;
  localparam logic [WOFS_W-1:0] W_FST_LO = 10'h34A;
  localparam logic [WOFS_W-1:0] W_FST_HI = 10'h34F;
  localparam logic [WOFS_W-1:0] W_SWTRIG = 10'h3C0;

  localparam logic [15:0] RST_KEY   = 16'h05FA;
  localparam int          RST_BIT   = 2;
  localparam int          NMI_BIT   = 31;
  localparam int          VB_LOW    = 7;

  typedef struct packed {
    logic ctype;
    logic ctrl;
    logic vbase;
    logic rstctl;
    logic hstat;
    logic fstat;
    logic swtrig;
  } hit_t;

  // set/clear pair table: exception, set bit, clear bit
  function automatic int pair_exc(input int i);
    return (i == 0) ? EXC_PENDSV : EXC_SYSTICK;
  endfunction

  function automatic int pair_set(input int i);
    return (i == 0) ? 28 : 26;
  endfunction

  function automatic int pair_clr(input int i);
    return (i == 0) ? 27 : 25;
  endfunction

  function automatic logic [DATA_W-1:0] ctype_value(input int num_irq);
    return DATA_W'((num_irq / 32) - 1);
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_pack(
      input logic [VEC_W-1:0] anum,
      input logic [VEC_W-1:0] tpend,
      input logic [EXC_W-1:0] pend);
    logic [DATA_W-1:0] v;
    v = '0;
    v[VEC_W-1:0]     = anum;
    v[12 +: VEC_W]   = tpend;
    v[26]            = pend[EXC_SYSTICK];
    v[28]            = pend[EXC_PENDSV];
    v[NMI_BIT]       = pend[EXC_NMI];
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] hstat_pack(
      input logic [EXC_W-1:0] act,
      input logic [EXC_W-1:0] pend,
      input logic [2:0]       fen);
    logic [DATA_W-1:0] v;
    v = '0;
    v[0]  = act[EXC_MEM];
    v[1]  = act[EXC_BUS];
    v[3]  = act[EXC_USAGE];
    v[7]  = act[EXC_SVC];
    v[8]  = act[EXC_DEBUG];
    v[10] = act[EXC_PENDSV];
    v[11] = act[EXC_SYSTICK];
    v[12] = pend[EXC_USAGE];
    v[13] = pend[EXC_MEM];
    v[14] = pend[EXC_BUS];
    v[15] = pend[EXC_SVC];
    v[18:16] = fen;
    return v;
  endfunction

endpackage

// File: rtl/sysexc_decode.sv
module sysexc_decode
  import sysexc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit,
  output logic              any_hit
);
  logic              aligned;
  logic [WOFS_W-1:0] w;

  assign aligned = (addr[1:0] == 2'b00);
  assign w       = addr[ADDR_W-1:2];

  always_comb begin
    hit        = '0;
    hit.ctype  = aligned && (w == W_CTYPE);
    hit.ctrl   = aligned && (w == W_CTRL);
    hit.vbase  = aligned && (w == W_VBASE);
    hit.rstctl = aligned && (w == W_RSTCTL);
    hit.hstat  = aligned && (w == W_HSTAT);
    hit.fstat  = aligned && (w >= W_FST_LO) && (w <= W_FST_HI);
    hit.swtrig = aligned && (w == W_SWTRIG);
  end

  assign any_hit = |hit;
endmodule

// File: rtl/sysexc_wrctl.sv
module sysexc_wrctl
  import sysexc_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  hit_t              hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              key_ok,
  output logic              trig_ok,
  output logic [EXC_W-1:0]  set_pend,
  output logic [EXC_W-1:0]  clr_pend,
  output logic              rst_req,
  output logic              trig_valid,
  output logic [VEC_W-1:0]  trig_num,
  output logic [DATA_W-1:0] vbase,
  output logic [2:0]        fault_en
);
  logic [EXC_W-1:0] set_nxt, clr_nxt;

  assign key_ok  = (wdata[DATA_W-1:16] == RST_KEY);
  assign trig_ok = (int'(wdata[VEC_W-1:0]) < NUM_IRQ);

  // set/clear strobes; set wins over clear within a pair
  always_comb begin
    set_nxt = '0;
    clr_nxt = '0;
    if (wr_fire && hit.ctrl) begin
      set_nxt[EXC_NMI] = wdata[NMI_BIT];
      for (int i = 0; i < N_PAIR; i++) begin
        if (wdata[pair_set(i)])
          set_nxt[pair_exc(i)] = 1'b1;
        else if (wdata[pair_clr(i)])
          clr_nxt[pair_exc(i)] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_pend   <= '0;
      clr_pend   <= '0;
      rst_req    <= 1'b0;
      trig_valid <= 1'b0;
      trig_num   <= '0;
      vbase      <= '0;
      fault_en   <= '0;
    end else begin
      set_pend   <= set_nxt;
      clr_pend   <= clr_nxt;
      rst_req    <= wr_fire && hit.rstctl && key_ok && wdata[RST_BIT];
      trig_valid <= wr_fire && hit.swtrig && trig_ok;
      if (wr_fire && hit.swtrig && trig_ok)
        trig_num <= wdata[VEC_W-1:0];
      if (wr_fire && hit.vbase)
        vbase <= {wdata[DATA_W-1:VB_LOW], {VB_LOW{1'b0}}};
      if (wr_fire && hit.hstat)
        fault_en <= {wdata[18], wdata[17], wdata[16]};
    end
  end
endmodule

// File: rtl/sysexc_rdmux.sv
module sysexc_rdmux
  import sysexc_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  hit_t              hit,
  input  logic              any_hit,
  input  logic [EXC_W-1:0]  exc_active,
  input  logic [EXC_W-1:0]  exc_pending,
  input  logic [VEC_W-1:0]  act_num,
  input  logic [VEC_W-1:0]  top_pend,
  input  logic [DATA_W-1:0] vbase,
  input  logic [2:0]        fault_en,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  logic [DATA_W-1:0] mux;

  always_comb begin
    mux = '0;
    unique case (1'b1)
      hit.ctype: mux = ctype_value(NUM_IRQ);
      hit.ctrl:  mux = ctrl_pack(act_num, top_pend, exc_pending);
      hit.vbase: mux = vbase;
      hit.hstat: mux = hstat_pack(exc_active, exc_pending, fault_en);
      default:   mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= rd_fire ? mux : '0;
      err   <= rd_fire && !any_hit;
    end
  end
endmodule

// File: rtl/sysexc_regfile.sv
module sysexc_regfile
  import sysexc_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  input  logic [15:0]       exc_active,
  input  logic [15:0]       exc_pending,
  input  logic [8:0]        act_num,
  input  logic [8:0]        top_pend,
  output logic [15:0]       set_pend,
  output logic [15:0]       clr_pend,
  output logic              rst_req,
  output logic              trig_valid,
  output logic [8:0]        trig_num,
  output logic [31:0]       vbase,
  output logic [2:0]        fault_en
);
  hit_t hit;
  logic any_hit;
  logic wr_fire, rd_fire;
  logic key_ok, trig_ok;
  logic hstat_wr;

  assign wr_fire  = reg_sel &&  reg_wr;
  assign rd_fire  = reg_sel && !reg_wr;
  assign hstat_wr = wr_fire && hit.hstat;

  sysexc_decode u_dec (
    .addr    (reg_addr),
    .hit     (hit),
    .any_hit (any_hit)
  );

  sysexc_wrctl #(.NUM_IRQ(NUM_IRQ)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .hit        (hit),
    .wdata      (reg_wdata),
    .key_ok     (key_ok),
    .trig_ok    (trig_ok),
    .set_pend   (set_pend),
    .clr_pend   (clr_pend),
    .rst_req    (rst_req),
    .trig_valid (trig_valid),
    .trig_num   (trig_num),
    .vbase      (vbase),
    .fault_en   (fault_en)
  );

  sysexc_rdmux #(.NUM_IRQ(NUM_IRQ)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_fire     (rd_fire),
    .hit         (hit),
    .any_hit     (any_hit),
    .exc_active  (exc_active),
    .exc_pending (exc_pending),
    .act_num     (act_num),
    .top_pend    (top_pend),
    .vbase       (vbase),
    .fault_en    (fault_en),
    .rdata       (reg_rdata),
    .err         (reg_err)
  );
endmodule

// File: rtl/sysexc_regfile_chk.sv
module sysexc_regfile_chk #(
  parameter int NUM_IRQ = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_fire,
  input logic        wr_fire,
  input logic        key_ok,
  input logic        hstat_wr,
  input logic        rstctl_hit,
  input logic        reg_err,
  input logic [15:0] set_pend,
  input logic [15:0] clr_pend,
  input logic        rst_req,
  input logic        trig_valid,
  input logic [8:0]  trig_num,
  input logic [31:0] vbase,
  input logic [2:0]  fault_en
);
  // R4 R5: never set and clear the same exception together
  a_r4_set_over_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pend & clr_pend) == 16'h0);

  // R8: reset request lasts one cycle and needs a keyed write before it
  a_r8_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r8_rst_keyed: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(wr_fire && rstctl_hit && key_ok));

  // R11: trigger number stays in range, pulse lasts one cycle
  a_r11_trig_range: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> (int'(trig_num) < NUM_IRQ));
  a_r11_trig_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |=> !trig_valid);

  // R7: low bits of the vector base are zero
  a_r7_vbase_align: assert property (@(posedge clk) disable iff (!rst_n)
    vbase[6:0] == 7'h0);

  // R10: fault enables move only after a handler-status write
  a_r10_fen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hstat_wr) |-> $stable(fault_en));

  // R13: error flag follows a read and lasts one cycle
  a_r13_err_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> $past(rd_fire));
endmodule

bind sysexc_regfile sysexc_regfile_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_fire    (rd_fire),
  .wr_fire    (wr_fire),
  .key_ok     (key_ok),
  .hstat_wr   (hstat_wr),
  .rstctl_hit (hit.rstctl),
  .reg_err    (reg_err),
  .set_pend   (set_pend),
  .clr_pend   (clr_pend),
  .rst_req    (rst_req),
  .trig_valid (trig_valid),
  .trig_num   (trig_num),
  .vbase      (vbase),
  .fault_en   (fault_en)
);

// File: tb/sysexc_regfile_test.sv
module sysexc_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic [15:0] exc_active = '0, exc_pending = '0;
  logic [8:0]  act_num = '0, top_pend = '0;
  logic [15:0] set_pend, clr_pend;
  logic        rst_req, trig_valid;
  logic [8:0]  trig_num;
  logic [31:0] vbase;
  logic [2:0]  fault_en;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysexc_regfile uut (.*);

  typedef struct packed {
    logic [11:0] addr;
    logic [15:0] act;
    logic [15:0] pend;
    logic [8:0]  an;
    logic [8:0]  tp;
    logic [31:0] exp;
    logic        err;
  } rvec_t;

  localparam int NRT = 9;
  localparam rvec_t RTBL [NRT] = '{
    '{12'h004, 16'h0000, 16'h0000, 9'h000, 9'h000, 32'h0000_0001, 1'b0}, // R2
    '{12'hD04, 16'h0000, 16'hC004, 9'h011, 9'h020, 32'h9402_0011, 1'b0}, // R6
    '{12'hD04, 16'hFFFF, 16'h4000, 9'h000, 9'h000, 32'h1000_0000, 1'b0}, // R6
    '{12'hD24, 16'hD870, 16'h0000, 9'h000, 9'h000, 32'h0000_0D8B, 1'b0}, // R9
    '{12'hD24, 16'h0000, 16'hC874, 9'h000, 9'h000, 32'h0000_F000, 1'b0}, // R9
    '{12'hD28, 16'hFFFF, 16'hFFFF, 9'h1FF, 9'h1FF, 32'h0000_0000, 1'b0}, // R12
    '{12'hD3C, 16'hFFFF, 16'hFFFF, 9'h1FF, 9'h1FF, 32'h0000_0000, 1'b0}, // R12
    '{12'hD08, 16'h0000, 16'h0000, 9'h000, 9'h000, 32'h0000_0000, 1'b0}, // R1
    '{12'h300, 16'hFFFF, 16'hFFFF, 9'h1FF, 9'h1FF, 32'h0000_0000, 1'b1}  // R13
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive on a falling edge, release on the next; outputs due then
  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic pulses_low(input string req);
    @(negedge clk);
    chk(req, {14'h0, rst_req, trig_valid, set_pend}, 32'h0);
    chk(req, {16'h0, clr_pend}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", reg_rdata, 32'h0);
    chk("R1", {reg_err, rst_req, trig_valid, trig_num, fault_en}, 32'h0);
    chk("R1", {set_pend, clr_pend}, 32'h0);
    chk("R1", vbase, 32'h0);

    for (int i = 0; i < NRT; i++) begin
      exc_active = RTBL[i].act; exc_pending = RTBL[i].pend;
      act_num = RTBL[i].an; top_pend = RTBL[i].tp;
      access(1'b0, RTBL[i].addr, 32'h0);
      chk("table", reg_rdata, RTBL[i].exp);
      chk("table err", {31'h0, reg_err}, {31'h0, RTBL[i].err});
    end
    @(negedge clk);
    chk("R13 err one cycle", {31'h0, reg_err}, 32'h0);
    exc_active = '0; exc_pending = '0; act_num = '0; top_pend = '0;

    // R3
    access(1'b1, 12'hD04, 32'h8000_0000);
    chk("R3 set", {16'h0, set_pend}, 32'h0000_0004);
    chk("R3 clr", {16'h0, clr_pend}, 32'h0);
    pulses_low("R3");
    // R4
    access(1'b1, 12'hD04, 32'h1800_0000);
    chk("R4 both set", {16'h0, set_pend}, 32'h0000_4000);
    chk("R4 both clr", {16'h0, clr_pend}, 32'h0);
    access(1'b1, 12'hD04, 32'h0800_0000);
    chk("R4 clr only", {set_pend, clr_pend}, 32'h0000_4000);
    // R5
    access(1'b1, 12'hD04, 32'h0600_0000);
    chk("R5 both", {set_pend, clr_pend}, 32'h8000_0000);
    access(1'b1, 12'hD04, 32'h0200_0000);
    chk("R5 clr only", {set_pend, clr_pend}, 32'h0000_8000);
    pulses_low("R5");

    // R7
    access(1'b1, 12'hD08, 32'h2000_00FF);
    chk("R7 port", vbase, 32'h2000_0080);
    access(1'b0, 12'hD08, 32'h0);
    chk("R7 read", reg_rdata, 32'h2000_0080);

    // R8
    access(1'b1, 12'hD0C, 32'h05FA_0004);
    chk("R8 pulse", {31'h0, rst_req}, 32'h1);
    pulses_low("R8");
    access(1'b1, 12'hD0C, 32'h1234_0004);
    chk("R8 bad key", {31'h0, rst_req}, 32'h0);
    access(1'b1, 12'hD0C, 32'h05FA_0000);
    chk("R8 no bit", {31'h0, rst_req}, 32'h0);

    // R10
    access(1'b1, 12'hD24, 32'hFFFF_FFFF);
    chk("R10 port", {29'h0, fault_en}, 32'h7);
    access(1'b0, 12'hD24, 32'h0);
    chk("R10 read", reg_rdata, 32'h0007_0000);
    access(1'b1, 12'hD24, 32'h0002_0000);
    chk("R10 bus only", {29'h0, fault_en}, 32'h2);

    // R11
    access(1'b1, 12'hF00, 32'h0000_003F);
    chk("R11 in range", {22'h0, trig_valid, trig_num}, {22'h0, 1'b1, 9'd63});
    pulses_low("R11");
    access(1'b1, 12'hF00, 32'h0000_0040);
    chk("R11 limit", {31'h0, trig_valid}, 32'h0);
    access(1'b1, 12'hF00, 32'hFFFF_FE05);
    chk("R11 field", {22'h0, trig_valid, trig_num}, {22'h0, 1'b1, 9'd5});

    // R13 unmapped write
    access(1'b1, 12'h300, 32'hFFFF_FFFF);
    chk("R13 wr strobes", {14'h0, rst_req, trig_valid, set_pend}, 32'h0);
    chk("R13 wr vbase", vbase, 32'h2000_0080);
    chk("R13 wr fen", {29'h0, fault_en}, 32'h2);
    chk("R13 wr rd", {31'h0, reg_err}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule